// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block is the part of a processor core that carries out one coprocessor instruction from start to finish. After a one-cycle start request it presents a sequence of phase codes to an attached coprocessor and reads back one response code per cycle. The instruction can be one of five kinds: a register write to the coprocessor, a register read from it, an internal coprocessor operation, a multi-word load, or a multi-word store. For loads and stores the block also produces the word address for each memory access.

While the coprocessor reports busy, the sequencer alternates an idle cycle with a new busy phase. In each idle cycle it checks three interrupt sources in priority order. If one is pending, it gives up the instruction and sends a single interrupt phase. A refusal from the coprocessor becomes an undefined-instruction or coprocessor-abort exception code. A memory abort seen during a burst is held and reported when the burst ends. A one-cycle done pulse closes every instruction, together with the exception code for that instruction.

Top module: `cpx_seq`

## Requirements
- R1: After reset the block is idle: `cp_phase` is 0 (none), `mem_rd`, `mem_wr`, `base_wb` and `done` are 0, and `exc_code` is 0 (none).
- R2: The cycle after `start` is sampled, `cp_phase` is 1 (first). A busy response (`cp_resp`=1) is followed by one idle cycle with phase 0, then phase 2 (busy). This repeats until a non-busy answer.
- R3: In each idle cycle of the busy wait, a pending interrupt makes the next cycle show phase 3 (interrupt) exactly once. The cycle after that is the done cycle, and `exc_code` names the source: 4 reset, 5 fast, 6 normal.
- R4: A cannot response (`cp_resp`=2) to a first or busy phase ends the instruction. The next cycle is done, with `exc_code` 1 (undefined) for ops 0, 1 and 2, or 2 (coprocessor abort) for ops 3 (load) and 4 (store). No memory access is made.
- R5: Interrupt priority is fixed. `reset_req_n` low wins. Next comes `fast_int_n` low with `fast_mask` clear, then `norm_int_n` low with `norm_mask` clear. A masked source does not break the busy wait.
- R6: A load (op 3) that is accepted shows phase 4 (transfer) for one cycle. Then phase 5 (data) shows with `mem_rd` high at `base_addr`. Each increment response (`cp_resp`=3) gives one more data cycle at the address plus 4.
- R7: A coprocessor register write (op 0) finishes one cycle after acceptance. A register read (op 1) finishes two cycles after acceptance. An internal operation (op 2) finishes in the cycle after acceptance.
- R8: When `wb_en` was high at start, `base_wb` pulses once, in the first memory-access cycle. Otherwise it stays low.
- R9: A `mem_abort` seen in any data cycle does not cut the burst short. The done cycle then reports `exc_code` 3 (memory abort).
- R10: `done` is high for exactly one cycle per instruction. `exc_code` is 0 in that cycle when the instruction completed cleanly.
- R11: An accepted store (op 4) goes straight to phase 5 with `mem_wr` high at `base_addr`. The address steps by 4 on each increment response, as for loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (one-cycle pulse while idle) |
| op | input | 3 | Instruction kind: 0 write, 1 read, 2 operation, 3 load, 4 store |
| base_addr | input | AW | Start address for memory transfers |
| wb_en | input | 1 | Base writeback requested |
| reset_req_n | input | 1 | Reset request, active low |
| fast_int_n | input | 1 | Fast interrupt, active low |
| fast_mask | input | 1 | Mask for the fast interrupt |
| norm_int_n | input | 1 | Normal interrupt, active low |
| norm_mask | input | 1 | Mask for the normal interrupt |
| cp_phase | output | 3 | Phase code presented to the coprocessor |
| cp_resp | input | 2 | Coprocessor answer: 0 ready, 1 busy, 2 cannot, 3 increment |
| mem_addr | output | AW | Word address of the current access |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_abort | input | 1 | Memory abort for the current access |
| base_wb | output | 1 | Base register update strobe |
| done | output | 1 | Instruction finished or abandoned |
| exc_code | output | 3 | Exception raised, valid with done |

## Verification
Two functions can meet in one instruction. The first is the stepping of burst addresses on increment answers. The second is the latching of a memory abort, which must not stop that stepping. The bench raises `mem_abort` on the middle word of a three-word load. It checks that all three addresses are still issued in order, and that the done cycle, and no earlier one, carries the memory-abort code. A second collision comes from holding all three interrupt sources active during a busy wait. The bench checks that only the highest unmasked source is reported, and that only one interrupt phase appears.

// File: rtl/cpx_pkg.sv
package cpx_pkg;

    typedef enum logic [2:0] {
        PH_NONE  = 3'd0,
        PH_FIRST = 3'd1,
        PH_BUSY  = 3'd2,
        PH_INTR  = 3'd3,
        PH_XFER  = 3'd4,
        PH_DATA  = 3'd5
    } phase_e;

    typedef enum logic [1:0] {
        RS_READY = 2'd0,
        RS_BUSY  = 2'd1,
        RS_CANT  = 2'd2,
        RS_INC   = 2'd3
    } resp_e;

    typedef enum logic [2:0] {
        OP_TOCP   = 3'd0,
        OP_FROMCP = 3'd1,
        OP_CALC   = 3'd2,
        OP_LOAD   = 3'd3,
        OP_STORE  = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        EX_NONE     = 3'd0,
        EX_UNDEF    = 3'd1,
        EX_CPABORT  = 3'd2,
        EX_MEMABORT = 3'd3,
        EX_RESET    = 3'd4,
        EX_FAST     = 3'd5,
        EX_NORM     = 3'd6
    } exc_e;

    function automatic logic is_mem_op(op_e o);
        return (o == OP_LOAD) || (o == OP_STORE);
    endfunction

endpackage

// File: rtl/cpx_int_arb.sv
module cpx_int_arb
    import cpx_pkg::*;
(
    input  logic reset_req_n,
    input  logic fast_int_n,
    input  logic fast_mask,
    input  logic norm_int_n,
    input  logic norm_mask,
    output logic pending,
    output exc_e code
);
    always_comb begin
        pending = 1'b1;
        code    = EX_NONE;
        if (!reset_req_n) begin
            code = EX_RESET;
        end else if (!fast_int_n && !fast_mask) begin
            code = EX_FAST;
        end else if (!norm_int_n && !norm_mask) begin
            code = EX_NORM;
        end else begin
            pending = 1'b0;
        end
    end
endmodule

// File: rtl/cpx_addr_gen.sv
module cpx_addr_gen #(
    parameter int AW         = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (load) begin
            addr <= base;
        end else if (step) begin
            addr <= addr + STEP;
        end
    end
endmodule

// File: rtl/cpx_ctrl.sv
module cpx_ctrl
    import cpx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  op_e    op_in,
    input  logic   wb_en,
    input  resp_e  resp,
    input  logic   int_pend,
    input  exc_e   int_code,
    input  logic   mem_abort,
    output phase_e phase,
    output logic   mem_rd,
    output logic   mem_wr,
    output logic   base_wb,
    output logic   addr_load,
    output logic   addr_step,
    output logic   done,
    output exc_e   exc
);
    typedef enum logic [3:0] {
        S_IDLE, S_FIRST, S_WAIT, S_BUSY, S_INTR,
        S_CCYC, S_ICYC, S_XFER, S_LDATA, S_SDATA, S_DONE
    } state_e;

    state_e state, nstate;
    op_e    op_q;
    logic   wb_q, first_q, abort_q;
    exc_e   exc_q, nexc;
    logic   set_exc;
    logic   in_data;

    assign in_data = (state == S_LDATA) || (state == S_SDATA);

    always_comb begin
        nstate    = state;
        nexc      = EX_NONE;
        set_exc   = 1'b0;
        phase     = PH_NONE;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        base_wb   = 1'b0;
        addr_load = 1'b0;
        addr_step = 1'b0;
        done      = 1'b0;
        case (state)
            S_IDLE: begin
                if (start) begin
                    addr_load = 1'b1;
                    nstate    = S_FIRST;
                end
            end
            S_FIRST, S_BUSY: begin
                phase = (state == S_FIRST) ? PH_FIRST : PH_BUSY;
                case (resp)
                    RS_BUSY: nstate = S_WAIT;
                    RS_CANT: begin
                        nstate  = S_DONE;
                        set_exc = 1'b1;
                        nexc    = is_mem_op(op_q) ? EX_CPABORT : EX_UNDEF;
                    end
                    default: begin
                        case (op_q)
                            OP_TOCP, OP_FROMCP: nstate = S_CCYC;
                            OP_LOAD:            nstate = S_XFER;
                            OP_STORE:           nstate = S_SDATA;
                            default:            nstate = S_DONE;
                        endcase
                    end
                endcase
            end
            S_WAIT: begin
                if (int_pend) begin
                    nstate  = S_INTR;
                    set_exc = 1'b1;
                    nexc    = int_code;
                end else begin
                    nstate = S_BUSY;
                end
            end
            S_INTR: begin
                phase  = PH_INTR;
                nstate = S_DONE;
            end
            S_CCYC: nstate = (op_q == OP_FROMCP) ? S_ICYC : S_DONE;
            S_ICYC: nstate = S_DONE;
            S_XFER: begin
                phase  = PH_XFER;
                nstate = S_LDATA;
            end
            S_LDATA, S_SDATA: begin
                phase   = PH_DATA;
                mem_rd  = (state == S_LDATA);
                mem_wr  = (state == S_SDATA);
                base_wb = first_q && wb_q;
                if (resp == RS_INC) begin
                    addr_step = 1'b1;
                end else begin
                    nstate = S_DONE;
                    if (abort_q || mem_abort) begin
                        set_exc = 1'b1;
                        nexc    = EX_MEMABORT;
                    end
                end
            end
            S_DONE: begin
                done   = 1'b1;
                nstate = S_IDLE;
            end
            default: nstate = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            op_q    <= OP_TOCP;
            wb_q    <= 1'b0;
            first_q <= 1'b0;
            abort_q <= 1'b0;
            exc_q   <= EX_NONE;
        end else begin
            state <= nstate;
            if (state == S_IDLE && start) begin
                op_q    <= op_in;
                wb_q    <= wb_en;
                first_q <= 1'b1;
                abort_q <= 1'b0;
                exc_q   <= EX_NONE;
            end else begin
                if (in_data) begin
                    first_q <= 1'b0;
                    abort_q <= abort_q | mem_abort;
                end
                if (set_exc) begin
                    exc_q <= nexc;
                end
            end
        end
    end

    assign exc = (state == S_DONE) ? exc_q : EX_NONE;
endmodule

// File: rtl/cpx_seq.sv
module cpx_seq
    import cpx_pkg::*;
#(
    parameter int AW         = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [2:0]    op,
    input  logic [AW-1:0] base_addr,
    input  logic          wb_en,
    input  logic          reset_req_n,
    input  logic          fast_int_n,
    input  logic          fast_mask,
    input  logic          norm_int_n,
    input  logic          norm_mask,
    output logic [2:0]    cp_phase,
    input  logic [1:0]    cp_resp,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    input  logic          mem_abort,
    output logic          base_wb,
    output logic          done,
    output logic [2:0]    exc_code
);
    logic   int_pend;
    exc_e   int_code;
    phase_e phase;
    exc_e   exc;
    logic   addr_load, addr_step;

    cpx_int_arb u_arb (
        .reset_req_n (reset_req_n),
        .fast_int_n  (fast_int_n),
        .fast_mask   (fast_mask),
        .norm_int_n  (norm_int_n),
        .norm_mask   (norm_mask),
        .pending     (int_pend),
        .code        (int_code)
    );

    cpx_addr_gen #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_addr (
        .clk  (clk),
        .rst  (rst),
        .load (addr_load),
        .step (addr_step),
        .base (base_addr),
        .addr (mem_addr)
    );

    cpx_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .op_in     (op_e'(op)),
        .wb_en     (wb_en),
        .resp      (resp_e'(cp_resp)),
        .int_pend  (int_pend),
        .int_code  (int_code),
        .mem_abort (mem_abort),
        .phase     (phase),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .base_wb   (base_wb),
        .addr_load (addr_load),
        .addr_step (addr_step),
        .done      (done),
        .exc       (exc)
    );

    assign cp_phase = phase;
    assign exc_code = exc;
endmodule

// File: rtl/cpx_seq_chk.sv
module cpx_seq_chk #(
    parameter int AW         = 16,
    parameter int WORD_BYTES = 4
) (
    input logic          clk,
    input logic          rst,
    input logic [2:0]    cp_phase,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          base_wb,
    input logic          done,
    input logic [2:0]    exc_code
);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    a_r2_busy_after_idle: assert property (@(posedge clk) disable iff (rst)
        (cp_phase == 3'd2) |-> ($past(cp_phase) == 3'd0));

    a_r3_intr_then_done: assert property (@(posedge clk) disable iff (rst)
        (cp_phase == 3'd3) |=> done);

    a_r4_undef_after_handshake: assert property (@(posedge clk) disable iff (rst)
        (done && exc_code == 3'd1) |-> ($past(cp_phase) == 3'd1 || $past(cp_phase) == 3'd2));

    a_r6_addr_step: assert property (@(posedge clk) disable iff (rst)
        (cp_phase == 3'd5 && $past(cp_phase) == 3'd5) |-> (mem_addr == $past(mem_addr) + STEP));

    a_r8_wb_with_access: assert property (@(posedge clk) disable iff (rst)
        base_wb |-> (mem_rd || mem_wr));

    a_r11_access_in_data: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) |-> (cp_phase == 3'd5 && !(mem_rd && mem_wr)));

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_exc_only_at_done: assert property (@(posedge clk) disable iff (rst)
        !done |-> (exc_code == 3'd0));
endmodule

bind cpx_seq cpx_seq_chk #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cp_phase (cp_phase),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .base_wb  (base_wb),
    .done     (done),
    .exc_code (exc_code)
);

// File: tb/cpx_seq_test.sv
`timescale 1ns/1ps
module cpx_seq_test;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [2:0]    op;
    logic [AW-1:0] base_addr;
    logic          wb_en;
    logic          reset_req_n, fast_int_n, fast_mask, norm_int_n, norm_mask;
    logic [2:0]    cp_phase;
    logic [1:0]    cp_resp;
    logic [AW-1:0] mem_addr;
    logic          mem_rd, mem_wr, mem_abort, base_wb, done;
    logic [2:0]    exc_code;

    int total = 0;
    int fails = 0;

    // coprocessor and memory models
    int          busy_left;
    int          inc_left;
    logic [1:0]  fin_resp;
    logic        abort_en;
    logic [AW-1:0] abort_at;

    // trace of one instruction
    int          n;
    logic [2:0]  tr_ph   [64];
    logic        tr_rd   [64];
    logic        tr_wr   [64];
    logic        tr_wb   [64];
    logic [AW-1:0] tr_ad [64];
    logic [2:0]  tr_exc;

    always #4 clk = ~clk;

    cpx_seq #(.AW(AW)) uut (
        .clk(clk), .rst(rst), .start(start), .op(op), .base_addr(base_addr),
        .wb_en(wb_en), .reset_req_n(reset_req_n), .fast_int_n(fast_int_n),
        .fast_mask(fast_mask), .norm_int_n(norm_int_n), .norm_mask(norm_mask),
        .cp_phase(cp_phase), .cp_resp(cp_resp), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_abort(mem_abort),
        .base_wb(base_wb), .done(done), .exc_code(exc_code)
    );

    always_comb begin
        if (cp_phase == 3'd1 || cp_phase == 3'd2)
            cp_resp = (busy_left > 0) ? 2'd1 : fin_resp;
        else if (cp_phase == 3'd5)
            cp_resp = (inc_left > 0) ? 2'd3 : 2'd0;
        else
            cp_resp = 2'd0;
    end

    assign mem_abort = abort_en && mem_rd && (mem_addr == abort_at);

    always @(posedge clk) begin
        if ((cp_phase == 3'd1 || cp_phase == 3'd2) && busy_left > 0)
            busy_left <= busy_left - 1;
        if (cp_phase == 3'd5 && inc_left > 0)
            inc_left <= inc_left - 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int count_ph(input logic [2:0] p);
        int c = 0;
        for (int i = 0; i < n; i++) if (tr_ph[i] == p) c++;
        return c;
    endfunction

    function automatic int first_idx(input logic [2:0] p);
        for (int i = 0; i < n; i++) if (tr_ph[i] == p) return i;
        return -1;
    endfunction

    function automatic int count_wb();
        int c = 0;
        for (int i = 0; i < n; i++) if (tr_wb[i]) c++;
        return c;
    endfunction

    task automatic run(input int o, input int base, input bit wb,
                       input int busy, input int fin, input int inc);
        @(negedge clk);
        busy_left = busy;
        inc_left  = inc;
        fin_resp  = 2'(fin);
        op        = 3'(o);
        base_addr = AW'(base);
        wb_en     = wb;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (n < 64) begin
            tr_ph[n] = cp_phase;
            tr_rd[n] = mem_rd;
            tr_wr[n] = mem_wr;
            tr_wb[n] = base_wb;
            tr_ad[n] = mem_addr;
            n++;
            if (done) begin
                tr_exc = exc_code;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 phase", int'(cp_phase), 0);
        chk("R1 strobes", int'({mem_rd, mem_wr, base_wb, done}), 0);
        chk("R1 exc", int'(exc_code), 0);
    endtask

    task automatic t_busy_write();
        run(0, 0, 0, 2, 0, 0);
        chk("R2 first phase", int'(tr_ph[0]), 1);
        chk("R2 idle after busy", int'(tr_ph[1]), 0);
        chk("R2 busy phase", int'(tr_ph[2]), 2);
        chk("R2 busy count", count_ph(3'd2), 2);
        chk("R7 write length", n, 7);
        chk("R10 clean exc", int'(tr_exc), 0);
    endtask

    task automatic t_reg_timing();
        run(1, 0, 0, 0, 0, 0);
        chk("R7 read length", n, 4);
        run(0, 0, 0, 0, 0, 0);
        chk("R7 write no busy length", n, 3);
        run(2, 0, 0, 0, 0, 0);
        chk("R7 operation length", n, 2);
    endtask

    task automatic t_cant();
        run(2, 0, 0, 1, 2, 0);
        chk("R4 cant length", n, 4);
        chk("R4 undef code", int'(tr_exc), 1);
        run(3, 16'h40, 0, 0, 2, 0);
        chk("R4 load cant code", int'(tr_exc), 2);
        chk("R4 no memory read", count_ph(3'd5), 0);
        run(4, 16'h40, 0, 0, 2, 0);
        chk("R4 store cant code", int'(tr_exc), 2);
    endtask

    task automatic t_intr();
        norm_int_n = 1'b0;
        run(0, 0, 0, 5, 0, 0);
        chk("R3 intr position", first_idx(3'd3), 2);
        chk("R3 intr once", count_ph(3'd3), 1);
        chk("R3 length", n, 4);
        chk("R3 normal code", int'(tr_exc), 6);
        norm_int_n = 1'b1;
    endtask

    task automatic t_priority();
        reset_req_n = 1'b0; fast_int_n = 1'b0; norm_int_n = 1'b0;
        run(2, 0, 0, 3, 0, 0);
        chk("R5 reset wins", int'(tr_exc), 4);
        reset_req_n = 1'b1;
        run(2, 0, 0, 3, 0, 0);
        chk("R5 fast over normal", int'(tr_exc), 5);
        fast_mask = 1'b1;
        run(2, 0, 0, 3, 0, 0);
        chk("R5 masked fast skipped", int'(tr_exc), 6);
        norm_mask = 1'b1;
        run(2, 0, 0, 1, 0, 0);
        chk("R5 all masked completes", int'(tr_exc), 0);
        chk("R5 all masked no intr", count_ph(3'd3), 0);
        fast_int_n = 1'b1; norm_int_n = 1'b1;
        fast_mask = 1'b0; norm_mask = 1'b0;
    endtask

    task automatic t_load();
        run(3, 16'h100, 1, 0, 0, 2);
        chk("R6 transfer phase", int'(tr_ph[1]), 4);
        chk("R6 data count", count_ph(3'd5), 3);
        chk("R6 addr0", int'(tr_ad[2]), 16'h100);
        chk("R6 addr1", int'(tr_ad[3]), 16'h104);
        chk("R6 addr2", int'(tr_ad[4]), 16'h108);
        chk("R6 reads", int'({tr_rd[2], tr_rd[3], tr_rd[4], tr_wr[2]}), 4'b1110);
        chk("R8 wb once", count_wb(), 1);
        chk("R8 wb on first word", int'(tr_wb[2]), 1);
        chk("R10 load clean", int'(tr_exc), 0);
    endtask

    task automatic t_store();
        run(4, 16'h200, 0, 0, 0, 1);
        chk("R11 data right after first", int'(tr_ph[1]), 5);
        chk("R11 addr0", int'(tr_ad[1]), 16'h200);
        chk("R11 addr1", int'(tr_ad[2]), 16'h204);
        chk("R11 writes", int'({tr_wr[1], tr_wr[2], tr_rd[1]}), 3'b110);
        chk("R11 length", n, 4);
        chk("R8 no wb when off", count_wb(), 0);
    endtask

    task automatic t_abort_burst();
        abort_en = 1'b1;
        abort_at = 16'h304;
        run(3, 16'h300, 0, 0, 0, 2);
        chk("R9 burst continues", count_ph(3'd5), 3);
        chk("R9 last addr", int'(tr_ad[4]), 16'h308);
        chk("R9 abort code at end", int'(tr_exc), 3);
        abort_en = 1'b0;
    endtask

    initial begin
        #(8ns * 50000);
        fails++;
        total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; op = '0; base_addr = '0; wb_en = 1'b0;
        reset_req_n = 1'b1; fast_int_n = 1'b1; norm_int_n = 1'b1;
        fast_mask = 1'b0; norm_mask = 1'b0;
        busy_left = 0; inc_left = 0; fin_resp = 2'd0;
        abort_en = 1'b0; abort_at = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_busy_write();
        t_reg_timing();
        t_cant();
        t_intr();
        t_priority();
        t_load();
        t_store();
        t_abort_burst();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule